// File: doc/BRIEF.md
# Paired Store-Release Execute Unit

This unit takes one decoded-on-the-fly paired store-release instruction and turns it into a single memory store request with release ordering. Each instruction arrives with the values of its two data registers, its base register and the stack pointer. The unit finds the element width and the addressing mode, and forms the effective address. It packs both data values into one double-width store, with the half order set by the endianness input. It then offers that store to memory over a valid/ready handshake.

When the pre-indexed form is used, the unit also reports the base-register update. The update is the decremented address, sent to the stack pointer or to a general register. It is visible only in the cycle the store is accepted. Some instructions do not produce a store: those that cannot execute, those caught by the data/base overlap rule, and those with a misaligned stack pointer. For these the unit gives a one-cycle outcome pulse instead of a request.

Instruction word layout handled by the unit: bit 31 is 1; bit 30 picks the element width; bits 29:21 equal 9'b011001000; bits 20:16 hold the second data register; bits 15:13 are 000; bit 12 picks the addressing form; bits 11:10 are 10; bits 9:5 hold the base register; bits 4:0 hold the first data register.

Top module: `pair_rel_store_unit`

## Requirements
- R1: A word is reported undefined (a `done_undef` pulse, no store) in two cases. The first is when `feat_en` is 0. The second is when any fixed field differs from the layout above.
- R2: With bit 30 clear, the elements are 32 bits wide. The store then covers 8 bytes, `mem_data[63:0]` is built from the low words of the sources, and `mem_data[127:64]` is zero. With bit 30 set, the elements are 64 bits wide and the store covers 16 bytes.
- R3: With bit 12 clear, the address is the base minus twice the element size (8 or 16 bytes) and writeback is on. With bit 12 set, the address is the base itself and writeback is off. `mem_hi_first` is 1 exactly when the offset is negative.
- R4: Base number 31 selects `sp_val` instead of `base_val`. In that case an `sp_val` whose low 4 bits are not zero gives a `done_align` pulse and no store. A misaligned `sp_val` has no effect when the base is any other register.
- R5: `mem_tag_check` is 1 when writeback is on or when the base number is not 31.
- R6: The overlap case is writeback on, the base not 31, and either data register number equal to the base number. In that case `ovl_policy` picks the outcome:
  - 0: store the values given.
  - 1: store all ones in place of each overlapping element.
  - 2: undefined.
  - 3: no-op (a `done_nop` pulse, no store).
- R7: With `big_endian` = 1, the first data register forms the upper half of the store data. With `big_endian` = 0, the second data register forms the upper half.
- R8: `wb_en` is 1 only while `mem_valid` and `mem_ready` are both 1 for a writeback-mode store. `wb_addr` then equals the store address. `wb_to_sp` is 1 and `wb_reg` is 31 when the base is the stack pointer; otherwise `wb_to_sp` is 0 and `wb_reg` holds the base number.
- R9: An accepted instruction shows its result in the next cycle. A pending request keeps `mem_valid`, address and data steady until `mem_ready`. While it is pending, `op_ready` is 0 and no new instruction is taken.
- R10: After reset no request or pulse is active. At most one of the store request and the three outcome pulses is active in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Paired-ordering feature present |
| big_endian | input | 1 | Data endianness for the store |
| ovl_policy | input | 2 | Overlap resolution choice |
| op_valid | input | 1 | Instruction offered |
| op_ready | output | 1 | Unit can take an instruction |
| insn | input | 32 | Instruction word |
| rt1_val | input | 64 | First data register value |
| rt2_val | input | 64 | Second data register value |
| base_val | input | 64 | General base register value |
| sp_val | input | 64 | Stack pointer value |
| mem_valid | output | 1 | Store request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Store address |
| mem_data | output | 128 | Packed store data |
| mem_bytes | output | 5 | Store size in bytes (8 or 16) |
| mem_release | output | 1 | Release ordering marker |
| mem_hi_first | output | 1 | Highest address written first |
| mem_tag_check | output | 1 | Access is tag-checked |
| wb_en | output | 1 | Base register update this cycle |
| wb_to_sp | output | 1 | Update targets the stack pointer |
| wb_reg | output | 5 | Base register number for the update |
| wb_addr | output | 64 | Value written to the base |
| done_undef | output | 1 | Undefined outcome pulse |
| done_nop | output | 1 | No-op outcome pulse |
| done_align | output | 1 | Stack alignment fault pulse |

## Verification
The bench goes after these failure modes:
- Overlap policies where only one of the two data registers matches the base. A unit that fills the wrong half with ones, or that applies the overlap rule when writeback is off or the base is the stack pointer, produces wrong data or a false undefined pulse.
- Word-size packing. Mixing up the halves leaks upper register bits into the store or swaps the words for one endianness.
- Backpressure. A unit that raises the base update before acceptance, or that takes a second instruction while busy, gives an early `wb_en` or a duplicate request.
- A misaligned stack pointer paired with a general base. This must still store normally.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [1:0] {
        OUT_STORE = 2'd0,
        OUT_UNDEF = 2'd1,
        OUT_NOP   = 2'd2,
        OUT_ALIGN = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        POL_KEEP    = 2'd0,
        POL_ONES    = 2'd1,
        POL_UNDEF   = 2'd2,
        POL_NOP     = 2'd3
    } policy_e;

    localparam logic [4:0] SP_INDEX = 5'd31;

    typedef struct packed {
        logic       match;
        logic       dbl;
        logic       wback;
        logic [4:0] rn;
        logic [4:0] rt;
        logic [4:0] rt2;
    } dec_t;

    // Fixed-field match plus field extraction.
    function automatic dec_t decode_word(input logic [31:0] w);
        dec_t d;
        d.match = w[31] && (w[29:21] == 9'b011001000) &&
                  (w[15:13] == 3'b000) && (w[11:10] == 2'b10);
        d.dbl   = w[30];
        d.wback = ~w[12];
        d.rt2   = w[20:16];
        d.rn    = w[9:5];
        d.rt    = w[4:0];
        return d;
    endfunction

endpackage

// File: rtl/psr_classify.sv
module psr_classify
    import psr_pkg::*;
(
    input  dec_t             dec,
    input  logic             feat_en,
    input  logic [1:0]       ovl_policy,
    input  logic             sp_misaligned,
    output outcome_e         outcome,
    output logic             fill1,
    output logic             fill2,
    output logic             tag_check
);
    logic    base_is_sp;
    logic    ovl1;
    logic    ovl2;
    policy_e pol;

    always_comb begin
        pol        = policy_e'(ovl_policy);
        base_is_sp = (dec.rn == SP_INDEX);
        ovl1       = dec.wback && !base_is_sp && (dec.rt  == dec.rn);
        ovl2       = dec.wback && !base_is_sp && (dec.rt2 == dec.rn);
        tag_check  = dec.wback || !base_is_sp;
        fill1      = ovl1 && (pol == POL_ONES);
        fill2      = ovl2 && (pol == POL_ONES);

        if (!feat_en || !dec.match)
            outcome = OUT_UNDEF;
        else if ((ovl1 || ovl2) && pol == POL_UNDEF)
            outcome = OUT_UNDEF;
        else if ((ovl1 || ovl2) && pol == POL_NOP)
            outcome = OUT_NOP;
        else if (base_is_sp && sp_misaligned)
            outcome = OUT_ALIGN;
        else
            outcome = OUT_STORE;
    end
endmodule

// File: rtl/psr_addr_gen.sv
module psr_addr_gen
    import psr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic [4:0]      rn,
    input  logic            dbl,
    input  logic            wback,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] sp_val,
    output logic [XLEN-1:0] addr,
    output logic            sp_misaligned,
    output logic            hi_first
);
    localparam int ELEM_BYTES_LO = 4;
    localparam int ELEM_BYTES_HI = XLEN / 8;

    logic [XLEN-1:0] src;
    logic [XLEN-1:0] dec_amt;

    always_comb begin
        src           = (rn == SP_INDEX) ? sp_val : base_val;
        sp_misaligned = |sp_val[SP_ALIGN_LG-1:0];
        dec_amt       = dbl ? XLEN'(2 * ELEM_BYTES_HI) : XLEN'(2 * ELEM_BYTES_LO);
        addr          = wback ? (src - dec_amt) : src;
        hi_first      = wback;
    end
endmodule

// File: rtl/psr_data_pack.sv
module psr_data_pack #(
    parameter int XLEN = 64
) (
    input  logic              dbl,
    input  logic              big_endian,
    input  logic              fill1,
    input  logic              fill2,
    input  logic [XLEN-1:0]   rt1_val,
    input  logic [XLEN-1:0]   rt2_val,
    output logic [2*XLEN-1:0] data
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] e1;
    logic [XLEN-1:0] e2;
    logic [XLEN-1:0] upper;
    logic [XLEN-1:0] lower;

    always_comb begin
        e1    = fill1 ? '1 : rt1_val;
        e2    = fill2 ? '1 : rt2_val;
        upper = big_endian ? e1 : e2;
        lower = big_endian ? e2 : e1;
        if (dbl)
            data = {upper, lower};
        else
            data = {{XLEN{1'b0}}, upper[HALF-1:0], lower[HALF-1:0]};
    end
endmodule

// File: rtl/pair_rel_store_unit.sv
module pair_rel_store_unit
    import psr_pkg::*;
#(
    parameter int XLEN        = 64,
    parameter int SP_ALIGN_LG = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  feat_en,
    input  logic                  big_endian,
    input  logic [1:0]            ovl_policy,
    input  logic                  op_valid,
    output logic                  op_ready,
    input  logic [31:0]           insn,
    input  logic [XLEN-1:0]       rt1_val,
    input  logic [XLEN-1:0]       rt2_val,
    input  logic [XLEN-1:0]       base_val,
    input  logic [XLEN-1:0]       sp_val,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [XLEN-1:0]       mem_addr,
    output logic [2*XLEN-1:0]     mem_data,
    output logic [$clog2(XLEN/4):0] mem_bytes,
    output logic                  mem_release,
    output logic                  mem_hi_first,
    output logic                  mem_tag_check,
    output logic                  wb_en,
    output logic                  wb_to_sp,
    output logic [4:0]            wb_reg,
    output logic [XLEN-1:0]       wb_addr,
    output logic                  done_undef,
    output logic                  done_nop,
    output logic                  done_align
);
    localparam int DATA_W  = 2 * XLEN;
    localparam int BYTES_W = $clog2(XLEN / 4) + 1;

    dec_t              dec;
    outcome_e          outcome;
    logic              fill1, fill2, tag_check;
    logic              sp_mis, hi_first;
    logic [XLEN-1:0]   addr;
    logic [DATA_W-1:0] data;
    logic              accept;

    assign dec = decode_word(insn);

    psr_classify u_classify (
        .dec           (dec),
        .feat_en       (feat_en),
        .ovl_policy    (ovl_policy),
        .sp_misaligned (sp_mis),
        .outcome       (outcome),
        .fill1         (fill1),
        .fill2         (fill2),
        .tag_check     (tag_check)
    );

    psr_addr_gen #(.XLEN(XLEN), .SP_ALIGN_LG(SP_ALIGN_LG)) u_addr (
        .rn            (dec.rn),
        .dbl           (dec.dbl),
        .wback         (dec.wback),
        .base_val      (base_val),
        .sp_val        (sp_val),
        .addr          (addr),
        .sp_misaligned (sp_mis),
        .hi_first      (hi_first)
    );

    psr_data_pack #(.XLEN(XLEN)) u_pack (
        .dbl        (dec.dbl),
        .big_endian (big_endian),
        .fill1      (fill1),
        .fill2      (fill2),
        .rt1_val    (rt1_val),
        .rt2_val    (rt2_val),
        .data       (data)
    );

    // Request / outcome register stage
    logic               vld_q, done_q;
    outcome_e           kind_q;
    logic [XLEN-1:0]    addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               dbl_q, hf_q, tag_q, wb_q, wbsp_q;
    logic [4:0]         rn_q;

    assign op_ready = !vld_q;
    assign accept   = op_valid && op_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            kind_q <= OUT_STORE;
        end else begin
            done_q <= 1'b0;
            if (vld_q && mem_ready)
                vld_q <= 1'b0;
            if (accept) begin
                kind_q <= outcome;
                if (outcome == OUT_STORE)
                    vld_q <= 1'b1;
                else
                    done_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            addr_q <= addr;
            data_q <= data;
            dbl_q  <= dec.dbl;
            hf_q   <= hi_first;
            tag_q  <= tag_check;
            wb_q   <= dec.wback;
            wbsp_q <= (dec.rn == SP_INDEX);
            rn_q   <= dec.rn;
        end
    end

    assign mem_valid     = vld_q;
    assign mem_addr      = addr_q;
    assign mem_data      = data_q;
    assign mem_bytes     = dbl_q ? BYTES_W'(XLEN / 4) : BYTES_W'(8);
    assign mem_release   = 1'b1;
    assign mem_hi_first  = hf_q;
    assign mem_tag_check = tag_q;
    assign wb_en         = vld_q && mem_ready && wb_q;
    assign wb_to_sp      = wbsp_q;
    assign wb_reg        = rn_q;
    assign wb_addr       = addr_q;
    assign done_undef    = done_q && (kind_q == OUT_UNDEF);
    assign done_nop      = done_q && (kind_q == OUT_NOP);
    assign done_align    = done_q && (kind_q == OUT_ALIGN);
endmodule

// File: rtl/pair_rel_store_unit_chk.sv
module pair_rel_store_unit_chk #(
    parameter int XLEN = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       op_ready,
    input logic                       mem_valid,
    input logic                       mem_ready,
    input logic [XLEN-1:0]            mem_addr,
    input logic [2*XLEN-1:0]          mem_data,
    input logic [$clog2(XLEN/4):0]    mem_bytes,
    input logic                       mem_hi_first,
    input logic                       mem_tag_check,
    input logic                       wb_en,
    input logic                       wb_to_sp,
    input logic [4:0]                 wb_reg,
    input logic                       done_undef,
    input logic                       done_nop,
    input logic                       done_align
);
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !op_ready);

    // R8
    wb_accept_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> mem_valid && mem_ready);

    // R8
    wb_sp_reg_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en && wb_to_sp |-> wb_reg == 5'd31);

    // R3
    hi_first_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_ready |-> mem_hi_first == wb_en);

    // R5
    tag_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_tag_check |-> !mem_hi_first);

    // R2
    size_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_bytes == 8 || mem_bytes == XLEN / 4));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_undef, done_nop, done_align, mem_valid}));
endmodule

bind pair_rel_store_unit pair_rel_store_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_ready      (op_ready),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_data      (mem_data),
    .mem_bytes     (mem_bytes),
    .mem_hi_first  (mem_hi_first),
    .mem_tag_check (mem_tag_check),
    .wb_en         (wb_en),
    .wb_to_sp      (wb_to_sp),
    .wb_reg        (wb_reg),
    .done_undef    (done_undef),
    .done_nop      (done_nop),
    .done_align    (done_align)
);

// File: tb/pair_rel_store_unit_tb.sv
`timescale 1ns/1ps
module pair_rel_store_unit_tb;

    localparam logic [63:0] V1   = 64'h1111_2222_3333_4444;
    localparam logic [63:0] V2   = 64'h5555_6666_7777_8888;
    localparam logic [63:0] BASE = 64'h0000_0000_0000_1000;
    localparam logic [63:0] SPV  = 64'h0000_0000_0000_2000;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic         s0;
        logic         ob;
        logic [4:0]   rt2;
        logic [4:0]   rn;
        logic [4:0]   rt;
        logic         be;
        logic [1:0]   pol;
        logic [1:0]   kind;   // 0 store, 1 undef, 2 nop
        logic [63:0]  addr;
        logic [127:0] data;
        logic         hf;
        logic         tag;
        logic         wb;
        logic         wbsp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 5'd2,  5'd5,  5'd1,  1'b0, 2'd0, 2'd0, 64'h0FF8, {64'h0, 64'h7777_8888_3333_4444}, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 5'd2,  5'd5,  5'd1,  1'b1, 2'd0, 2'd0, 64'h1000, {V1, V2},                        1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 5'd2,  5'd31, 5'd1,  1'b0, 2'd0, 2'd0, 64'h1FF0, {V2, V1},                        1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 5'd2,  5'd31, 5'd1,  1'b1, 2'd0, 2'd0, 64'h2000, {64'h0, 64'h3333_4444_7777_8888}, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 5'd2,  5'd5,  5'd5,  1'b0, 2'd1, 2'd0, 64'h0FF0, {V2, ONES},                      1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 5'd5,  5'd5,  5'd1,  1'b1, 2'd1, 2'd0, 64'h0FF8, {64'h0, 64'h3333_4444_FFFF_FFFF}, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 5'd2,  5'd5,  5'd5,  1'b0, 2'd2, 2'd1, 64'h0,    128'h0,                          1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 5'd5,  5'd5,  5'd1,  1'b0, 2'd3, 2'd2, 64'h0,    128'h0,                          1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 5'd2,  5'd5,  5'd5,  1'b0, 2'd0, 2'd0, 64'h0FF0, {V2, V1},                        1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b1, 5'd2,  5'd5,  5'd5,  1'b0, 2'd2, 2'd0, 64'h1000, {V2, V1},                        1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 5'd2,  5'd31, 5'd31, 1'b1, 2'd2, 2'd0, 64'h1FF0, {V1, V2},                        1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 1'b1, 5'd2,  5'd31, 5'd1,  1'b0, 2'd0, 2'd0, 64'h2000, {64'h0, 64'h7777_8888_3333_4444}, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         feat_en = 1'b1;
    logic         big_endian = 1'b0;
    logic [1:0]   ovl_policy = 2'd0;
    logic         op_valid = 1'b0;
    logic         op_ready;
    logic [31:0]  insn = 32'h0;
    logic [63:0]  rt1_val = V1;
    logic [63:0]  rt2_val = V2;
    logic [63:0]  base_val = BASE;
    logic [63:0]  sp_val = SPV;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic [4:0]   mem_bytes;
    logic         mem_release, mem_hi_first, mem_tag_check;
    logic         wb_en, wb_to_sp;
    logic [4:0]   wb_reg;
    logic [63:0]  wb_addr;
    logic         done_undef, done_nop, done_align;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    pair_rel_store_unit u_dut (
        .clk(clk), .rst(rst), .feat_en(feat_en), .big_endian(big_endian),
        .ovl_policy(ovl_policy), .op_valid(op_valid), .op_ready(op_ready),
        .insn(insn), .rt1_val(rt1_val), .rt2_val(rt2_val),
        .base_val(base_val), .sp_val(sp_val), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_bytes(mem_bytes), .mem_release(mem_release),
        .mem_hi_first(mem_hi_first), .mem_tag_check(mem_tag_check),
        .wb_en(wb_en), .wb_to_sp(wb_to_sp), .wb_reg(wb_reg), .wb_addr(wb_addr),
        .done_undef(done_undef), .done_nop(done_nop), .done_align(done_align)
    );

    function automatic logic [31:0] enc(input logic s0, input logic ob,
                                        input logic [4:0] r2, input logic [4:0] n,
                                        input logic [4:0] r1);
        return {1'b1, s0, 9'b011001000, r2, 3'b000, ob, 2'b10, n, r1};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one instruction, leave it accepted, sample at the next negedge.
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        insn = w;
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 reset mem_valid", 128'(mem_valid), 128'd0);
        chk("R10 reset pulses", 128'({done_undef, done_nop, done_align, wb_en}), 128'd0);
        chk("R9 reset op_ready", 128'(op_ready), 128'd1);

        for (int i = 0; i < NV; i++) begin
            big_endian = VECS[i].be;
            ovl_policy = VECS[i].pol;
            issue(enc(VECS[i].s0, VECS[i].ob, VECS[i].rt2, VECS[i].rn, VECS[i].rt));
            if (VECS[i].kind == 2'd0) begin
                chk("R9 store issued", 128'(mem_valid), 128'd1);
                chk("R3 R4 address", 128'(mem_addr), 128'(VECS[i].addr));
                chk("R6 R7 R2 data", mem_data, VECS[i].data);
                chk("R2 bytes", 128'(mem_bytes), VECS[i].s0 ? 128'd16 : 128'd8);
                chk("R3 hi_first", 128'(mem_hi_first), 128'(VECS[i].hf));
                chk("R5 tag check", 128'(mem_tag_check), 128'(VECS[i].tag));
                chk("R8 no wb before accept", 128'(wb_en), 128'd0);
                mem_ready = 1'b1;
                #1;
                chk("R8 wb_en on accept", 128'(wb_en), 128'(VECS[i].wb));
                if (VECS[i].wb) begin
                    chk("R8 wb target", 128'({wb_to_sp, wb_reg}), 128'({VECS[i].wbsp, VECS[i].rn}));
                    chk("R8 wb value", 128'(wb_addr), 128'(VECS[i].addr));
                end
                @(negedge clk);
                mem_ready = 1'b0;
                chk("R9 request retired", 128'(mem_valid), 128'd0);
            end else begin
                chk("R6 R10 no store", 128'(mem_valid), 128'd0);
                chk("R6 outcome pulse", 128'({done_undef, done_nop}),
                    VECS[i].kind == 2'd1 ? 128'd2 : 128'd1);
                @(negedge clk);
                chk("R10 pulse one cycle", 128'({done_undef, done_nop}), 128'd0);
            end
        end

        // R1 feature disabled
        big_endian = 1'b0;
        ovl_policy = 2'd0;
        feat_en = 1'b0;
        issue(enc(1'b1, 1'b0, 5'd2, 5'd5, 5'd1));
        chk("R1 feature off undef", 128'({done_undef, mem_valid}), 128'd2);
        feat_en = 1'b1;

        // R1 bad fixed field (bit 29 set)
        issue(enc(1'b1, 1'b0, 5'd2, 5'd5, 5'd1) | 32'h2000_0000);
        chk("R1 bad encoding undef", 128'({done_undef, mem_valid}), 128'd2);

        // R4 misaligned stack pointer with base 31
        sp_val = 64'h2008;
        issue(enc(1'b0, 1'b1, 5'd2, 5'd31, 5'd1));
        chk("R4 align fault", 128'({done_align, mem_valid}), 128'd2);

        // R4 misaligned stack pointer ignored for a general base
        issue(enc(1'b0, 1'b1, 5'd2, 5'd7, 5'd1));
        chk("R4 general base unaffected", 128'({done_align, mem_valid}), 128'd1);
        chk("R4 general base address", 128'(mem_addr), 128'h1000);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        sp_val = SPV;

        // R9 backpressure: hold, refuse new work, update only on accept
        issue(enc(1'b1, 1'b0, 5'd2, 5'd5, 5'd1));
        insn = enc(1'b0, 1'b1, 5'd2, 5'd6, 5'd1);
        op_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 held valid", 128'(mem_valid), 128'd1);
            chk("R9 held address", 128'(mem_addr), 128'h0FF0);
            chk("R9 busy op_ready", 128'(op_ready), 128'd0);
            chk("R8 no wb while stalled", 128'(wb_en), 128'd0);
        end
        op_valid = 1'b0;
        mem_ready = 1'b1;
        #1;
        chk("R8 wb on late accept", 128'(wb_en), 128'd1);
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R9 blocked op not taken", 128'(mem_valid), 128'd0);

        finish_run();
    end
endmodule